// File: doc/BRIEF.md
# Plane-Masked Raster Operation Unit

This unit is one execution slot of a wide vector data path that is split into 32-bit lanes. It keeps two pieces of state: a 32-bit plane mask and a 4-bit raster function code. A configuration instruction loads both. A raster instruction then applies the stored two-input boolean function to the source operand B and the destination operand A in every lane.

The function result is written only at the bit positions that the plane mask enables. At every other bit position the result carries operand A through unchanged. The same mask applies to all lanes. The result is registered and appears one cycle after the instruction is accepted.

Instruction fetch and the register file sit outside this unit. The unit sees only a valid strobe, a 5-bit opcode and the two wide operands.

Top module: `rop_unit`

## Requirements
- R1: While reset is high and in the cycle after it, `res_valid` is 0 and `res_data` is all zeros. After reset the plane mask is all ones and the function code is 4'hC (copy source), so an unconfigured raster instruction returns operand B.
- R2: A raster instruction (opcode 2) computes, at each enabled bit, bit `code[{b,a}]`, where b is the bit of operand B and a is the bit of operand A. Code bit 0 therefore covers b=0,a=0, bit 1 covers b=0,a=1, bit 2 covers b=1,a=0 and bit 3 covers b=1,a=1.
- R3: At every bit where the plane mask is 0, the raster result equals operand A.
- R4: Every 32-bit lane uses the same plane mask and code. Lane k of the result depends only on lane k of the operands.
- R5: A configuration instruction (opcode 12) loads the plane mask from operand A bits [31:0] and the code from operand A bits [35:32]. All other bits of A and all bits of B have no effect.
- R6: A configuration instruction produces a valid result whose data is all zeros.
- R7: A new mask and code take effect from the instruction after the configuration instruction, including an instruction in the very next cycle.
- R8: `res_valid` is 1 exactly one cycle after `op_valid` is high with opcode 2 or 12, and 0 otherwise. Any other opcode, or any opcode presented while `op_valid` is low, leaves the mask and code unchanged.
- R9: In a cycle with no result, `res_data` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Instruction presented this cycle |
| op_code | input | 5 | Instruction opcode (2 = raster, 12 = configure) |
| opnd_a | input | 256 | Destination / configuration operand, eight 32-bit lanes |
| opnd_b | input | 256 | Source operand, eight 32-bit lanes |
| res_valid | output | 1 | Result valid, one cycle after an accepted instruction |
| res_data | output | 256 | Registered result |

## Verification
All 16 function codes are swept under four plane masks: all ones, all zeros, the low half set, and alternating bits. The operands differ per lane and contain every {b,a} bit combination, so any misplaced truth-table bit or lane mix-up changes the result. The sweep also shows whether masked bits keep A rather than clearing to zero.

Each configuration is issued with junk in the unused operand bits and is followed at once by a raster instruction. This exposes a code taken from the wrong field or a configuration that takes effect a cycle late. Configurations presented with `op_valid` low or under a foreign opcode, followed by a raster instruction, show that no state was touched. Pseudo-random operand pairs then cover the data path beyond the fixed patterns.

// File: rtl/rop_pkg.sv
package rop_pkg;
  localparam int OP_W      = 5;
  localparam int FN_W      = 4;
  localparam logic [OP_W-1:0] OPC_RASTER = 5'd2;
  localparam logic [OP_W-1:0] OPC_CONFIG = 5'd12;
  // truth table indexed by {src_bit, dst_bit}; 4'hC returns the source bit
  localparam logic [FN_W-1:0] FN_COPY_SRC = 4'hC;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'd0,
    ACT_RASTER = 2'd1,
    ACT_CONFIG = 2'd2
  } act_e;
endpackage

// File: rtl/rop_lane.sv
module rop_lane
  import rop_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0]    src,
  input  logic [W-1:0]    dst,
  input  logic [W-1:0]    mask,
  input  logic [FN_W-1:0] fn,
  output logic [W-1:0]    res
);
  logic [W-1:0] fn_out;

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_bit
      assign fn_out[i] = fn[{src[i], dst[i]}];
    end
  endgenerate

  assign res = (fn_out & mask) | (dst & ~mask);
endmodule

// File: rtl/rop_cfg.sv
module rop_cfg
  import rop_pkg::*;
#(
  parameter int W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [W-1:0]    mask_in,
  input  logic [FN_W-1:0] fn_in,
  output logic [W-1:0]    mask,
  output logic [FN_W-1:0] fn
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mask <= '1;
      fn   <= FN_COPY_SRC;
    end else if (load) begin
      mask <= mask_in;
      fn   <= fn_in;
    end
  end
endmodule

// File: rtl/rop_unit.sv
module rop_unit
  import rop_pkg::*;
#(
  parameter int LANES  = 8,
  parameter int LANE_W = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    op_valid,
  input  logic [4:0]              op_code,
  input  logic [LANES*LANE_W-1:0] opnd_a,
  input  logic [LANES*LANE_W-1:0] opnd_b,
  output logic                    res_valid,
  output logic [LANES*LANE_W-1:0] res_data
);
  localparam int DW = LANES * LANE_W;

  act_e               act;
  logic [LANE_W-1:0]  plane_mask;
  logic [FN_W-1:0]    fn_code;
  logic [DW-1:0]      lane_res;

  always_comb begin
    act = ACT_NONE;
    if (op_valid) begin
      if (op_code == OPC_RASTER)      act = ACT_RASTER;
      else if (op_code == OPC_CONFIG) act = ACT_CONFIG;
    end
  end

  rop_cfg #(.W(LANE_W)) u_cfg (
    .clk     (clk),
    .rst     (rst),
    .load    (act == ACT_CONFIG),
    .mask_in (opnd_a[LANE_W-1:0]),
    .fn_in   (opnd_a[LANE_W +: FN_W]),
    .mask    (plane_mask),
    .fn      (fn_code)
  );

  genvar k;
  generate
    for (k = 0; k < LANES; k++) begin : g_lane
      rop_lane #(.W(LANE_W)) u_lane (
        .src  (opnd_b[k*LANE_W +: LANE_W]),
        .dst  (opnd_a[k*LANE_W +: LANE_W]),
        .mask (plane_mask),
        .fn   (fn_code),
        .res  (lane_res[k*LANE_W +: LANE_W])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_data  <= '0;
    end else begin
      res_valid <= (act != ACT_NONE);
      if (act == ACT_RASTER)      res_data <= lane_res;
      else if (act == ACT_CONFIG) res_data <= '0;
    end
  end
endmodule

// File: rtl/rop_unit_chk.sv
module rop_unit_chk #(
  parameter int LANES  = 8,
  parameter int LANE_W = 32
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    op_valid,
  input logic [4:0]              op_code,
  input logic [LANES*LANE_W-1:0] opnd_a,
  input logic                    res_valid,
  input logic [LANES*LANE_W-1:0] res_data,
  input logic [LANE_W-1:0]       plane_mask
);
  logic [LANES*LANE_W-1:0] mask_all;
  logic acc, is_rast, is_cfg;

  assign mask_all = {LANES{plane_mask}};
  assign is_rast  = op_valid && (op_code == 5'd2);
  assign is_cfg   = op_valid && (op_code == 5'd12);
  assign acc      = is_rast || is_cfg;

  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (!res_valid && res_data == '0));

  p_keep_dst_r3: assert property (@(posedge clk) disable iff (rst)
    is_rast |=> (((res_data ^ $past(opnd_a)) & ~$past(mask_all)) == '0));

  p_cfg_zero_r6: assert property (@(posedge clk) disable iff (rst)
    is_cfg |=> (res_valid && res_data == '0));

  p_valid_after_r8: assert property (@(posedge clk) disable iff (rst)
    acc |=> res_valid);

  p_no_valid_r8: assert property (@(posedge clk) disable iff (rst)
    !acc |=> !res_valid);

  p_mask_still_r8: assert property (@(posedge clk) disable iff (rst)
    !is_cfg |=> $stable(plane_mask));

  p_hold_data_r9: assert property (@(posedge clk) disable iff (rst)
    !acc |=> $stable(res_data));
endmodule

bind rop_unit rop_unit_chk #(.LANES(LANES), .LANE_W(LANE_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .op_valid   (op_valid),
  .op_code    (op_code),
  .opnd_a     (opnd_a),
  .res_valid  (res_valid),
  .res_data   (res_data),
  .plane_mask (plane_mask)
);

// File: tb/tb_rop_unit.sv
module tb_rop_unit;
  localparam int LANES = 8;
  localparam int LW    = 32;
  localparam int DW    = LANES * LW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          op_valid = 1'b0;
  logic [4:0]    op_code = '0;
  logic [DW-1:0] opnd_a = '0;
  logic [DW-1:0] opnd_b = '0;
  logic          res_valid;
  logic [DW-1:0] res_data;

  int checks = 0;
  int errors = 0;

  logic [LW-1:0] m_mask = '1;
  logic [3:0]    m_fn   = 4'hC;
  logic [DW-1:0] m_last = '0;
  logic [31:0]   lfsr   = 32'h1ACE_B00C;

  always #10 clk = ~clk;

  rop_unit #(.LANES(LANES), .LANE_W(LW)) dut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .res_valid(res_valid), .res_data(res_data)
  );

  function automatic logic [DW-1:0] model(input logic [DW-1:0] a, input logic [DW-1:0] b,
                                          input logic [LW-1:0] m, input logic [3:0] f);
    logic [DW-1:0] r;
    for (int i = 0; i < DW; i++) begin
      if (m[i % LW]) r[i] = f[{b[i], a[i]}];
      else           r[i] = a[i];
    end
    return r;
  endfunction

  task automatic check(input string req, input logic v, input logic [DW-1:0] d,
                       input logic ev, input logic [DW-1:0] ed);
    checks++;
    if (v !== ev || d !== ed) begin
      errors++;
      $display("FAIL %s valid=%0b data=%h expected valid=%0b data=%h", req, v, d, ev, ed);
    end
  endtask

  // drive at negedge, sample just after the following posedge
  task automatic step(input logic v, input logic [4:0] op,
                      input logic [DW-1:0] a, input logic [DW-1:0] b);
    @(negedge clk);
    op_valid = v; op_code = op; opnd_a = a; opnd_b = b;
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  function automatic logic [DW-1:0] pat_a();
    logic [DW-1:0] r;
    for (int k = 0; k < LANES; k++) r[k*LW +: LW] = 32'hFF00_FF00 ^ (k * 32'h0101_0101);
    return r;
  endfunction

  function automatic logic [DW-1:0] pat_b();
    logic [DW-1:0] r;
    for (int k = 0; k < LANES; k++) r[k*LW +: LW] = 32'hF0F0_F0F0 ^ (k * 32'h0011_0011);
    return r;
  endfunction

  function automatic logic [DW-1:0] cfg_word(input logic [LW-1:0] m, input logic [3:0] f);
    logic [DW-1:0] r;
    r = {DW{1'b1}} ^ {8{32'h5A5A_3C3C}};   // junk in unused bits
    r[LW-1:0]  = m;
    r[LW +: 4] = f;
    return r;
  endfunction

  task automatic next_rand(output logic [DW-1:0] v);
    for (int k = 0; k < LANES; k++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      v[k*LW +: LW] = lfsr ^ (k * 32'h9E37_79B9);
    end
  endtask

  initial begin
    #4_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [LW-1:0] masks [4];
    logic [DW-1:0] ra, rb, exp_d;
    masks[0] = 32'hFFFF_FFFF; masks[1] = 32'h0000_0000;
    masks[2] = 32'h0000_FFFF; masks[3] = 32'hAAAA_AAAA;

    repeat (3) @(posedge clk);
    #1;
    check("R1 reset", res_valid, res_data, 1'b0, '0);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    check("R1 after reset", res_valid, res_data, 1'b0, '0);

    // R1: default configuration copies B
    step(1'b1, 5'd2, pat_a(), pat_b());
    check("R1 default copy", res_valid, res_data, 1'b1, pat_b());
    m_last = pat_b();

    // R8/R9: foreign opcode gives no result and holds data
    step(1'b1, 5'd5, cfg_word(32'h0, 4'h0), pat_a());
    check("R8 R9 foreign opcode", res_valid, res_data, 1'b0, m_last);
    step(1'b0, 5'd12, cfg_word(32'h0, 4'h0), pat_a());
    check("R8 R9 invalid strobe", res_valid, res_data, 1'b0, m_last);
    step(1'b1, 5'd2, pat_b(), pat_a());
    check("R8 config untouched", res_valid, res_data, 1'b1, pat_a());

    // R2 R3 R4 R5 R6 R7: sweep codes and masks, config followed at once by raster
    for (int mi = 0; mi < 4; mi++) begin
      for (int f = 0; f < 16; f++) begin
        step(1'b1, 5'd12, cfg_word(masks[mi], f[3:0]), {DW{1'b1}});
        check("R5 R6 config result", res_valid, res_data, 1'b1, '0);
        m_mask = masks[mi]; m_fn = f[3:0];
        step(1'b1, 5'd2, pat_a(), pat_b());
        exp_d = model(pat_a(), pat_b(), m_mask, m_fn);
        check("R2 R3 R4 R7 raster", res_valid, res_data, 1'b1, exp_d);
        m_last = exp_d;
      end
    end

    // R9: gap cycle holds last raster result
    step(1'b0, 5'd2, '0, '0);
    check("R9 hold", res_valid, res_data, 1'b0, m_last);

    // random operands under a mixed configuration
    step(1'b1, 5'd12, cfg_word(32'h0F0F_33CC, 4'h6), '0);
    check("R6 config result", res_valid, res_data, 1'b1, '0);
    m_mask = 32'h0F0F_33CC; m_fn = 4'h6;
    for (int t = 0; t < 40; t++) begin
      next_rand(ra); next_rand(rb);
      step(1'b1, 5'd2, ra, rb);
      check("R2 R3 random", res_valid, res_data, 1'b1, model(ra, rb, m_mask, m_fn));
    end
    idle();

    @(posedge clk); #1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule